// File: doc/BRIEF.md
# Fast Vectored Interrupt Redirect Unit

This unit sits between an external interrupt controller and a processor's instruction fetch steering. When the controller offers a pending interrupt with a nonzero identifier, the unit takes it and stores the identifier in a claim register that software can read later. It then builds the address of that identifier's vector slot from a table base and reads the handler address from a closely coupled single-port SRAM. Finally it presents that handler address to the fetch stage as a redirect, which the core acknowledges. The whole sequence is fixed hardware with no firmware instructions, so the redirect appears three cycles after acceptance.

Each slot holds one 32-bit handler address. The slot address is the upper part of the table base (a 1 KiB aligned region) with the 8-bit identifier shifted left by two below it. Identifier 0 means that nothing is pending. With the build option `FAST_EN` cleared, the unit keeps only the claim capture. It then never touches the SRAM or the fetch redirect, and software performs the lookup.

Top module: `irq_vec_redirect`

## Requirements
- R1: A request is accepted (`irq_accept_o` high) in a cycle where `irq_valid_i` is high, `irq_id_i` is nonzero and the unit is not busy. `claim_id_o` shows the accepted identifier from the next cycle on and keeps it until the next acceptance. It resets to 0.
- R2: A request with identifier 0 is never accepted, and it leaves `claim_id_o` and `busy_o` unchanged.
- R3: In the cycle after acceptance, and only then, `mem_req_o` is high for exactly one cycle. In that cycle `mem_addr_o` = {`tbl_base_i`, identifier, 2'b00}, with the base on bits 31:10 and the identifier on bits 9:2.
- R4: The SRAM returns data in the cycle after `mem_req_o`. With no error, `redir_valid_o` rises three cycles after the acceptance cycle, and `redir_pc_o` equals the word that was read.
- R5: `redir_valid_o` and `redir_pc_o` hold steady until a cycle with `redir_ack_i` high. The unit is idle in the following cycle.
- R6: Requests that arrive while a sequence runs are not accepted. A request held high is accepted in the first idle cycle, which is the cycle after the acknowledge or the cycle of the error pulse.
- R7: If `mem_err_i` is high in the data cycle, no redirect is issued. Instead `err_o` is high for one cycle, three cycles after acceptance, and the unit is idle in that cycle.
- R8: `busy_o` is high from the cycle after acceptance until the sequence ends: through the acknowledge cycle after a redirect, or through the data cycle when the read fails.
- R9: With `FAST_EN` = 0, any nonzero valid request is accepted and captured into `claim_id_o` in the next cycle. `mem_req_o`, `redir_valid_o`, `err_o` and `busy_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid_i | input | 1 | Interrupt controller has a winning request |
| irq_id_i | input | 8 | Identifier of the winning request |
| irq_accept_o | output | 1 | Request taken this cycle |
| tbl_base_i | input | 22 | Vector table base, address bits 31:10 |
| claim_id_o | output | 8 | Persistent captured claim identifier |
| mem_req_o | output | 1 | SRAM read strobe |
| mem_addr_o | output | 32 | SRAM byte address of the vector slot |
| mem_rdata_i | input | 32 | SRAM read word, one cycle after the strobe |
| mem_err_i | input | 1 | SRAM read error, valid with the read word |
| redir_valid_o | output | 1 | Fetch redirect request |
| redir_pc_o | output | 32 | Handler address to fetch from |
| redir_ack_i | input | 1 | Core took the redirect |
| err_o | output | 1 | One-cycle pulse on an aborted lookup |
| busy_o | output | 1 | Redirect sequence in progress |

## Verification
Two events can fall in the same cycle: the end of a sequence, and the acceptance of a request that has been waiting. After a read error, the error pulse and the next acceptance coincide. After a redirect, the acknowledge cycle directly precedes the next acceptance. The bench provokes both by raising the next request while the previous sequence is still running and holding it high. A scoreboard, fed with the expected identifier, handler word and error outcome for each request, judges each case. It checks that nothing is accepted while busy and that each outcome appears exactly three cycles after its own acceptance. It also checks that the claim register moves to the new identifier only one cycle after the new acceptance.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int ID_W   = 8;
    localparam int ADDR_W = 32;
    localparam int DATA_W = ADDR_W;
    localparam int SLOT_SH = 2;
    localparam int BASE_W = ADDR_W - ID_W - SLOT_SH;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOOKUP,
        SEQ_RESP,
        SEQ_REDIR
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] pc;
    } redir_t;

    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [BASE_W-1:0] base,
        input logic [ID_W-1:0]   id
    );
        return {base, id, {SLOT_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/irqv_claim_reg.sv
module irqv_claim_reg
    import irqv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [ID_W-1:0] id_in,
    output logic [ID_W-1:0] claim_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            claim_o <= '0;
        end else if (capture) begin
            claim_o <= id_in;
        end
    end

    assert_claim_capture_R1: assert property (@(posedge clk) disable iff (rst)
        capture |=> claim_o == $past(id_in));

    assert_claim_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(claim_o));

endmodule

// File: rtl/irqv_addr_gen.sv
module irqv_addr_gen
    import irqv_pkg::*;
(
    input  logic [BASE_W-1:0] base_i,
    input  logic [ID_W-1:0]   id_i,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        addr_o = slot_addr(base_i, id_i);
    end

endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] slot_addr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_err_i,
    output redir_t            redir_o,
    input  logic              ack_i,
    output logic              err_o,
    output logic              busy_o
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pc_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) state_q <= SEQ_LOOKUP;
                end
                SEQ_LOOKUP: begin
                    state_q <= SEQ_RESP;
                end
                SEQ_RESP: begin
                    if (mem_err_i) begin
                        err_q   <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        pc_q    <= mem_rdata_i[ADDR_W-1:0];
                        state_q <= SEQ_REDIR;
                    end
                end
                SEQ_REDIR: begin
                    if (ack_i) state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o     = (state_q == SEQ_LOOKUP);
        mem_addr_o    = slot_addr_i;
        redir_o.valid = (state_q == SEQ_REDIR);
        redir_o.pc    = pc_q;
        err_o         = err_q;
        busy_o        = (state_q != SEQ_IDLE);
    end

    assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    assert_redir_word_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RESP && !mem_err_i) |=>
            (redir_o.valid && redir_o.pc == $past(mem_rdata_i)));

    assert_redir_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (redir_o.valid && !ack_i) |=> (redir_o.valid && $stable(redir_o.pc)));

    assert_err_no_redir_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RESP && mem_err_i) |=> (err_o && !redir_o.valid));

endmodule

// File: rtl/irq_vec_redirect.sv
module irq_vec_redirect
    import irqv_pkg::*;
#(
    parameter bit FAST_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_valid_i,
    input  logic [ID_W-1:0]   irq_id_i,
    output logic              irq_accept_o,
    input  logic [BASE_W-1:0] tbl_base_i,
    output logic [ID_W-1:0]   claim_id_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_err_i,
    output logic              redir_valid_o,
    output logic [ADDR_W-1:0] redir_pc_o,
    input  logic              redir_ack_i,
    output logic              err_o,
    output logic              busy_o
);

    logic seq_busy;

    always_comb begin
        irq_accept_o = irq_valid_i && (irq_id_i != '0) && !seq_busy;
    end

    irqv_claim_reg u_claim (
        .clk     (clk),
        .rst     (rst),
        .capture (irq_accept_o),
        .id_in   (irq_id_i),
        .claim_o (claim_id_o)
    );

    generate
        if (FAST_EN) begin : g_fast
            logic [ADDR_W-1:0] slot;
            redir_t            redir;

            irqv_addr_gen u_addr (
                .base_i (tbl_base_i),
                .id_i   (claim_id_o),
                .addr_o (slot)
            );

            irqv_seq u_seq (
                .clk         (clk),
                .rst         (rst),
                .start_i     (irq_accept_o),
                .slot_addr_i (slot),
                .mem_req_o   (mem_req_o),
                .mem_addr_o  (mem_addr_o),
                .mem_rdata_i (mem_rdata_i),
                .mem_err_i   (mem_err_i),
                .redir_o     (redir),
                .ack_i       (redir_ack_i),
                .err_o       (err_o),
                .busy_o      (seq_busy)
            );

            always_comb begin
                redir_valid_o = redir.valid;
                redir_pc_o    = redir.pc;
            end

            assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
                irq_accept_o |=> busy_o);

            assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
                busy_o |-> !irq_accept_o);
        end else begin : g_claim_only
            logic unused_lite;
            always_comb begin
                seq_busy      = 1'b0;
                mem_req_o     = 1'b0;
                mem_addr_o    = '0;
                redir_valid_o = 1'b0;
                redir_pc_o    = '0;
                err_o         = 1'b0;
                unused_lite   = ^{tbl_base_i, mem_rdata_i, mem_err_i, redir_ack_i};
            end
        end
    endgenerate

    always_comb begin
        busy_o = seq_busy;
    end

    assert_zero_id_R2: assert property (@(posedge clk) disable iff (rst)
        irq_accept_o |-> (irq_valid_i && irq_id_i != '0));

endmodule

// File: tb/irq_vec_redirect_tb_top.sv
module irq_vec_redirect_tb_top;
    import irqv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [ID_W-1:0] ERR_ID = 8'd77;

    typedef struct {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] pc;
        bit                err;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              irq_valid = 1'b0;
    logic [ID_W-1:0]   irq_id = '0;
    logic [BASE_W-1:0] tbl_base = 22'h2A5C3;
    logic              redir_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_err = 1'b0;

    logic              acc, mem_req, redir_valid, err_p, busy;
    logic [ID_W-1:0]   claim;
    logic [ADDR_W-1:0] mem_addr, redir_pc;

    logic              l_acc, l_req, l_rv, l_err, l_busy;
    logic [ID_W-1:0]   l_claim;
    logic [ADDR_W-1:0] l_addr, l_pc;

    int  checks = 0;
    int  failures = 0;
    int  cyc = 0;
    int  ack_wait = 0;
    bit  done = 1'b0;
    exp_t exp_q[$];

    irq_vec_redirect #(.FAST_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .irq_valid_i(irq_valid), .irq_id_i(irq_id),
        .irq_accept_o(acc), .tbl_base_i(tbl_base), .claim_id_o(claim),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_err_i(mem_err), .redir_valid_o(redir_valid), .redir_pc_o(redir_pc),
        .redir_ack_i(redir_ack), .err_o(err_p), .busy_o(busy)
    );

    irq_vec_redirect #(.FAST_EN(1'b0)) dut_lite_i (
        .clk(clk), .rst(rst), .irq_valid_i(irq_valid), .irq_id_i(irq_id),
        .irq_accept_o(l_acc), .tbl_base_i(tbl_base), .claim_id_o(l_claim),
        .mem_req_o(l_req), .mem_addr_o(l_addr), .mem_rdata_i(32'h0),
        .mem_err_i(1'b0), .redir_valid_o(l_rv), .redir_pc_o(l_pc),
        .redir_ack_i(1'b0), .err_o(l_err), .busy_o(l_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [ADDR_W-1:0] tbl_word(logic [ID_W-1:0] id);
        return 32'h4000_0000 + 32'(id) * 32'h104;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // single-port vector table model, one cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= tbl_word(mem_addr[9:2]);
            mem_err   <= (mem_addr[9:2] == ERR_ID);
        end
    end

    // acknowledge driver for the fetch side
    int hold_cnt = 0;
    always begin
        @(posedge clk);
        #1;
        if (redir_ack) begin
            redir_ack = 1'b0;
        end else if (redir_valid) begin
            if (hold_cnt >= ack_wait) begin
                redir_ack = 1'b1;
                hold_cnt  = 0;
            end else begin
                hold_cnt++;
            end
        end
    end

    // monitor / scoreboard
    int               acc_cyc = -100;
    logic [ID_W-1:0]  acc_id = '0;
    int               l_acc_cyc = -100;
    logic [ID_W-1:0]  l_acc_id = '0;
    bit               mb = 1'b0;
    bit               redir_seen = 1'b0;
    bit               p_rv = 1'b0;
    bit               p_ack = 1'b0;
    logic [ADDR_W-1:0] p_pc = '0;

    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            check(busy == mb, "R8", "busy", 32'(busy), 32'(mb));
            if (cyc > acc_cyc)
                check(claim == acc_id, "R1", "claim value", 32'(claim), 32'(acc_id));
            if (cyc == acc_cyc + 1) begin
                check(mem_req == 1'b1, "R3", "read strobe", 32'(mem_req), 32'd1);
                check(mem_addr == {tbl_base, acc_id, 2'b00}, "R3", "slot address",
                      mem_addr, {tbl_base, acc_id, 2'b00});
            end else begin
                check(mem_req == 1'b0, "R3", "stray strobe", 32'(mem_req), 32'd0);
            end
            if (p_rv && !p_ack)
                check(redir_valid && redir_pc == p_pc, "R5", "redirect hold", redir_pc, p_pc);
            if (redir_valid && !redir_seen) begin
                redir_seen = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected redirect", redir_pc, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(!e.err, "R7", "redirect after read error", 32'd1, 32'd0);
                    check(redir_pc == e.pc, "R4", "handler address", redir_pc, e.pc);
                    check(cyc == acc_cyc + 3, "R4", "redirect latency",
                          32'(cyc - acc_cyc), 32'd3);
                end
            end
            if (err_p) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected error", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.err, "R7", "error flag", 32'd1, 32'(e.err));
                    check(cyc == acc_cyc + 3, "R7", "error latency", 32'(cyc - acc_cyc), 32'd3);
                    check(!redir_valid, "R7", "redirect with error", 32'(redir_valid), 32'd0);
                end
            end
            if (acc) begin
                check(!mb, "R6", "accept while busy", 32'd1, 32'd0);
                check(irq_valid && irq_id != '0, "R2", "accepted id", 32'(irq_id), 32'd1);
                if (exp_q.size() > 0)
                    check(exp_q[$].id == irq_id, "R1", "accepted id order",
                          32'(irq_id), 32'(exp_q[$].id));
            end else if (!mb && irq_valid && irq_id != '0) begin
                check(1'b0, "R6", "idle request not taken", 32'd0, 32'd1);
            end
            // claim-only build
            check(!l_req && !l_rv && !l_err && !l_busy, "R9", "lite outputs quiet",
                  32'({l_req, l_rv, l_err, l_busy}), 32'd0);
            check(l_acc == (irq_valid && irq_id != '0), "R9", "lite accept",
                  32'(l_acc), 32'(irq_valid && irq_id != '0));
            if (cyc > l_acc_cyc)
                check(l_claim == l_acc_id, "R9", "lite claim", 32'(l_claim), 32'(l_acc_id));
            if (l_acc) begin
                l_acc_cyc = cyc;
                l_acc_id  = irq_id;
            end
            // model next-cycle busy
            p_rv  = redir_valid;
            p_ack = redir_ack;
            p_pc  = redir_pc;
            if (acc) begin
                mb      = 1'b1;
                acc_cyc = cyc;
                acc_id  = irq_id;
            end else if (redir_valid && redir_ack) begin
                mb         = 1'b0;
                redir_seen = 1'b0;
            end else if (mb && cyc == acc_cyc + 2 && exp_q.size() > 0 && exp_q[0].err) begin
                mb = 1'b0;
            end
        end
    end

    task automatic fire(logic [ID_W-1:0] id);
        exp_t e;
        e.id  = id;
        e.pc  = tbl_word(id);
        e.err = (id == ERR_ID);
        exp_q.push_back(e);
        @(posedge clk);
        #1;
        irq_valid = 1'b1;
        irq_id    = id;
        do @(negedge clk); while (!acc);
        @(posedge clk);
        #1;
        irq_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || busy);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        logic [ID_W-1:0] keep;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // reset state (R1, R8)
        check(claim == '0, "R1", "claim after reset", 32'(claim), 32'd0);
        check(!busy && !redir_valid && !err_p, "R8", "idle after reset",
              32'({busy, redir_valid, err_p}), 32'd0);

        // basic lookups with immediate acknowledge, incl. maximum identifier
        ack_wait = 0;
        fire(8'd1);
        fire(8'd255);
        drain();

        // slow acknowledge, back-to-back requests held while busy (R5, R6)
        ack_wait = 3;
        fire(8'd5);
        fire(8'd9);
        // read error followed by a waiting request (R7, R6)
        fire(ERR_ID);
        fire(8'd10);
        drain();

        // identifier 0 is ignored (R2)
        keep = claim;
        @(posedge clk);
        #1;
        irq_valid = 1'b1;
        irq_id    = 8'd0;
        repeat (5) @(negedge clk);
        check(!busy, "R2", "busy after zero id", 32'(busy), 32'd0);
        check(claim == keep, "R2", "claim after zero id", 32'(claim), 32'(keep));
        @(posedge clk);
        #1;
        irq_valid = 1'b0;

        // other base and mid identifiers
        ack_wait = 1;
        fire(8'd128);
        fire(8'd2);
        drain();
        tbl_base = 22'h3FFFFF;
        fire(8'd200);
        fire(ERR_ID);
        drain();

        check(exp_q.size() == 0, "R4", "all outcomes seen", 32'(exp_q.size()), 32'd0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule